// File: doc/BRIEF.md
# Packet Payload Buffer Pair

This block holds packet payload bytes between a host register interface and a serial packet engine. It has two byte-wide FIFOs of 16 entries. The host fills one with transmit payload and the engine drains it. The engine fills the other with received payload and the host drains it. A payload of up to 16 bytes can be written in one burst, and the engine then sends it with no further host action.

Longer packets, up to 40 bytes, stream through the same storage. A transmit-space interrupt tells the host when it can add more bytes. A receive-data interrupt tells it when bytes are waiting. The host programs a packet length. The block counts engine reads against that length and flags completion.

Two sticky flags record a transmit underrun and a receive overflow. While the engine handles an acknowledge packet, it marks its accesses with a qualifier. Those accesses leave both buffers untouched. A clear strobe empties both buffers. DEPTH must be a power of two.

Top module: `pkt_payload_bufs`

## Requirements
- R1: The transmit buffer holds up to 16 bytes. A host write stores a byte when the buffer is not full. A host write to a full buffer is ignored, and `tx_level` stays at 16.
- R2: `e_tx_data` shows the oldest transmit byte. An engine read removes that byte only while a packet is active (`tx_count < tx_length`) and the buffer holds data. Bytes leave in the order they were written.
- R3: A length write loads `h_len` and zeroes `tx_count`. Each byte-removing engine read adds one to `tx_count`. `tx_done` is 1 when the length is nonzero and `tx_count` equals it. Engine reads after that point are ignored.
- R4: `irq_tx_space` is 1 exactly when a packet is active and at least 4 entries are free.
- R5: An engine write stores a byte in the receive buffer when the buffer is not full. `h_rd_data` shows the oldest received byte. A host read removes that byte when the buffer is not empty.
- R6: `irq_rx_data` is 1 exactly when the receive buffer holds at least 4 bytes.
- R7: An engine write to a full receive buffer is dropped, and it sets the sticky `rx_overflow`. The full check uses the level at the start of the cycle, even when the host reads in the same cycle.
- R8: An engine read while a packet is active and the transmit buffer is empty sets the sticky `tx_underrun`. That read leaves `tx_count` unchanged.
- R9: While `e_ack` is 1, engine reads and writes do nothing: no data is removed or stored, no counter changes and no flag changes.
- R10: `h_buf_clr` empties both buffers and clears both flags, `tx_count` and `rx_count`. It overrides any host or engine access in the same cycle. It keeps the programmed length, and a length write in the same cycle still loads the length.
- R11: `rx_count` counts every engine write made without `e_ack`, including dropped ones. It wraps modulo 64.
- R12: After reset, both buffers are empty, the length and both counters are 0, and all flags and interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| h_wr_en | input | 1 | Host writes a transmit byte |
| h_wr_data | input | 8 | Transmit byte from host |
| h_rd_en | input | 1 | Host takes a received byte |
| h_rd_data | output | 8 | Oldest received byte |
| h_len_wr | input | 1 | Host loads the packet length |
| h_len | input | 6 | Packet length value |
| h_buf_clr | input | 1 | Clear strobe for buffers, counters and flags |
| e_tx_rd | input | 1 | Engine consumes a transmit byte |
| e_tx_data | output | 8 | Oldest transmit byte |
| e_rx_wr | input | 1 | Engine produces a received byte |
| e_rx_data | input | 8 | Received byte from engine |
| e_ack | input | 1 | Engine access belongs to an acknowledge packet |
| tx_level | output | 5 | Bytes held in the transmit buffer |
| rx_level | output | 5 | Bytes held in the receive buffer |
| tx_count | output | 6 | Bytes consumed in the current packet |
| rx_count | output | 6 | Engine receive writes since clear |
| tx_done | output | 1 | Count has reached the nonzero length |
| irq_tx_space | output | 1 | Transmit space interrupt |
| irq_rx_data | output | 1 | Receive data interrupt |
| tx_underrun | output | 1 | Sticky transmit underrun flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |

## Verification
The assertions assume that `e_ack` only comes with engine strobes and that the host does not touch the buffers while an acknowledge access is checked for stability. The acknowledge property therefore applies only in cycles with no host write, host read or clear. The stimulus drives every input on the falling edge. It mixes directed bursts, a 40-byte streaming transfer, deliberate underruns and overflows, and a long random phase. In that phase `e_ack`, `h_buf_clr` and length writes occur at random but stay rare, so the buffers reach both full and empty.

// File: rtl/pkt_payload_bufs.sv
module pkt_payload_bufs #(
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 6,
  parameter int THRESH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_wr_en,
  input  logic [7:0]       h_wr_data,
  input  logic             h_rd_en,
  output logic [7:0]       h_rd_data,
  input  logic             h_len_wr,
  input  logic [LEN_W-1:0] h_len,
  input  logic             h_buf_clr,
  input  logic             e_tx_rd,
  output logic [7:0]       e_tx_data,
  input  logic             e_rx_wr,
  input  logic [7:0]       e_rx_data,
  input  logic             e_ack,
  output logic [$clog2(DEPTH+1)-1:0] tx_level,
  output logic [$clog2(DEPTH+1)-1:0] rx_level,
  output logic [LEN_W-1:0] tx_count,
  output logic [LEN_W-1:0] rx_count,
  output logic             tx_done,
  output logic             irq_tx_space,
  output logic             irq_rx_data,
  output logic             tx_underrun,
  output logic             rx_overflow
);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [7:0]       tx_mem [DEPTH];
  logic [7:0]       rx_mem [DEPTH];
  logic [PW-1:0]    tx_wp, tx_rp, rx_wp, rx_rp;
  logic [LEN_W-1:0] len_q;

  wire tx_full   = tx_level == LW'(DEPTH);
  wire tx_empty  = tx_level == '0;
  wire rx_full   = rx_level == LW'(DEPTH);
  wire rx_empty  = rx_level == '0;
  wire tx_active = tx_count < len_q;

  wire eng_rd   = e_tx_rd && !e_ack && tx_active;
  wire tx_pop   = eng_rd && !tx_empty;
  wire tx_push  = h_wr_en && !tx_full;
  wire eng_wr   = e_rx_wr && !e_ack;
  wire rx_push  = eng_wr && !rx_full;
  wire rx_pop   = h_rd_en && !rx_empty;

  assign e_tx_data    = tx_mem[tx_rp];
  assign h_rd_data    = rx_mem[rx_rp];
  assign tx_done      = (len_q != '0) && (tx_count == len_q);
  assign irq_tx_space = tx_active && (tx_level <= LW'(DEPTH - THRESH));
  assign irq_rx_data  = rx_level >= LW'(THRESH);

  always_ff @(posedge clk) begin
    if (tx_push && !h_buf_clr) tx_mem[tx_wp] <= h_wr_data;
    if (rx_push && !h_buf_clr) rx_mem[rx_wp] <= e_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
      tx_level <= '0; rx_level <= '0;
      len_q <= '0; tx_count <= '0; rx_count <= '0;
      tx_underrun <= 1'b0; rx_overflow <= 1'b0;
    end else begin
      if (h_len_wr) len_q <= h_len;
      if (h_buf_clr) begin
        tx_wp <= '0; tx_rp <= '0; rx_wp <= '0; rx_rp <= '0;
        tx_level <= '0; rx_level <= '0;
        tx_count <= '0; rx_count <= '0;
        tx_underrun <= 1'b0; rx_overflow <= 1'b0;
      end else begin
        if (tx_push) tx_wp <= tx_wp + 1'b1;
        if (tx_pop)  tx_rp <= tx_rp + 1'b1;
        tx_level <= tx_level + LW'(tx_push) - LW'(tx_pop);
        if (h_len_wr)    tx_count <= '0;
        else if (tx_pop) tx_count <= tx_count + 1'b1;
        if (eng_rd && tx_empty) tx_underrun <= 1'b1;

        if (rx_push) rx_wp <= rx_wp + 1'b1;
        if (rx_pop)  rx_rp <= rx_rp + 1'b1;
        rx_level <= rx_level + LW'(rx_push) - LW'(rx_pop);
        if (eng_wr) rx_count <= rx_count + 1'b1;
        if (eng_wr && rx_full) rx_overflow <= 1'b1;
      end
    end
  end

  AST_TX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH)); // R1
  AST_RX_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LW'(DEPTH)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= len_q); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_overflow && !h_buf_clr) |=> rx_overflow); // R7
  AST_UND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_underrun && !h_buf_clr) |=> tx_underrun); // R8
  AST_RX_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (e_rx_wr && !e_ack && rx_full && !h_rd_en && !h_buf_clr) |=> (rx_full && rx_overflow)); // R7
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ack && !h_wr_en && !h_rd_en && !h_buf_clr && !h_len_wr) |=>
      ($stable(tx_level) && $stable(rx_level) && $stable(tx_count) && $stable(rx_count))); // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    h_buf_clr |=> (tx_level == '0 && rx_level == '0 && !tx_underrun && !rx_overflow)); // R10
endmodule

// File: tb/tb_pkt_payload_bufs.sv
`timescale 1ns/1ps
module tb_pkt_payload_bufs;
  logic clk = 0, rst_n = 0;
  logic h_wr_en = 0, h_rd_en = 0, h_len_wr = 0, h_buf_clr = 0;
  logic e_tx_rd = 0, e_rx_wr = 0, e_ack = 0;
  logic [7:0] h_wr_data = 0, e_rx_data = 0;
  logic [5:0] h_len = 0;
  logic [7:0] h_rd_data, e_tx_data;
  logic [4:0] tx_level, rx_level;
  logic [5:0] tx_count, rx_count;
  logic tx_done, irq_tx_space, irq_rx_data, tx_underrun, rx_overflow;

  pkt_payload_bufs dut (.*);

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] mq_tx[$], mq_rx[$];
  int m_len = 0, m_cnt = 0, m_rxc = 0;
  bit m_und = 0, m_ovf = 0;

  task automatic chk(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1", "tx_level", tx_level, mq_tx.size());
    chk("R5", "rx_level", rx_level, mq_rx.size());
    chk("R3", "tx_count", tx_count, m_cnt);
    chk("R11", "rx_count", rx_count, m_rxc);
    chk("R3", "tx_done", tx_done, (m_len != 0 && m_cnt == m_len));
    chk("R4", "irq_tx_space", irq_tx_space, (m_cnt < m_len && 16 - mq_tx.size() >= 4));
    chk("R6", "irq_rx_data", irq_rx_data, (mq_rx.size() >= 4));
    chk("R8", "tx_underrun", tx_underrun, m_und);
    chk("R7", "rx_overflow", rx_overflow, m_ovf);
    if (mq_tx.size() > 0) chk("R2", "e_tx_data", e_tx_data, mq_tx[0]);
    if (mq_rx.size() > 0) chk("R5", "h_rd_data", h_rd_data, mq_rx[0]);
  endtask

  task automatic step(bit wr, logic [7:0] wd, bit rd, bit lw, logic [5:0] lv,
                      bit clr, bit etr, bit erw, logic [7:0] ed, bit ack);
    int tl, rl;
    bit act;
    check_all();
    h_wr_en = wr; h_wr_data = wd; h_rd_en = rd; h_len_wr = lw; h_len = lv;
    h_buf_clr = clr; e_tx_rd = etr; e_rx_wr = erw; e_rx_data = ed; e_ack = ack;
    if (clr) begin
      mq_tx.delete(); mq_rx.delete();
      m_cnt = 0; m_rxc = 0; m_und = 0; m_ovf = 0;
    end else begin
      tl = mq_tx.size(); rl = mq_rx.size(); act = m_cnt < m_len;
      if (etr && !ack && act) begin
        if (tl > 0) begin
          void'(mq_tx.pop_front());
          if (!lw) m_cnt++;
        end else m_und = 1;
      end
      if (lw) m_cnt = 0;
      if (wr && tl < 16) mq_tx.push_back(wd);
      if (rd && rl > 0) void'(mq_rx.pop_front());
      if (erw && !ack) begin
        m_rxc = (m_rxc + 1) % 64;
        if (rl < 16) mq_rx.push_back(ed); else m_ovf = 1;
      end
    end
    if (lw) m_len = lv;
    @(posedge clk); @(negedge clk);
    h_wr_en = 0; h_rd_en = 0; h_len_wr = 0; h_buf_clr = 0;
    e_tx_rd = 0; e_rx_wr = 0; e_ack = 0;
  endtask

  initial begin
    #(20 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int sent;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12", "reset tx_level", tx_level, 0);
    chk("R12", "reset rx_level", rx_level, 0);
    chk("R12", "reset irqs", {irq_tx_space, irq_rx_data, tx_done}, 0);
    chk("R12", "reset flags", {tx_underrun, rx_overflow}, 0);

    // R1 burst fill plus writes to a full buffer
    for (int i = 0; i < 20; i++) step(1, 8'(8'h30 + i), 0, 0, 0, 0, 0, 0, 0, 0);
    // R2 R3 short packet, then extra reads after done
    step(0, 0, 0, 1, 10, 0, 0, 0, 0, 0);
    for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R10 clear with collisions
    step(1, 8'h55, 1, 1, 40, 1, 1, 1, 8'h66, 0);
    // R3 R4 40-byte streaming packet
    sent = 0;
    for (int c = 0; c < 200 && m_cnt < 40; c++) begin
      bit w = (sent < 40) && (mq_tx.size() < 16) && (c < 16 || irq_tx_space || c[0]);
      step(w, 8'(sent * 7), 0, 0, 0, 0, c[0] | c[1], 0, 0, 0);
      if (w) sent++;
    end
    // R8 underrun on empty buffer
    step(0, 0, 0, 1, 5, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // R5 R6 R7 overflow, including a same-cycle host read
    for (int i = 0; i < 18; i++) step(0, 0, 0, 0, 0, 0, 0, 1, 8'(8'hA0 + i), 0);
    step(0, 0, 1, 0, 0, 0, 0, 1, 8'hEE, 0);
    for (int i = 0; i < 18; i++) step(0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R9 ack accesses do nothing
    step(1, 8'h11, 0, 1, 3, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 1, 1, 8'h77, 1);
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 1), 8'($urandom), $urandom_range(0, 1),
           r < 3, 6'($urandom_range(0, 40)), r == 50,
           $urandom_range(0, 2) != 0, $urandom_range(0, 1), 8'($urandom), r > 92);
    end
    check_all();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule